// File: doc/BRIEF.md
# Round-Robin Channel Monitoring Sequencer

This block drives the periodic measurement loop of a hardware health monitor. It walks a fixed list of nine channels: one temperature channel, six supply-voltage channels and two fan tachometer channels. For each channel it asks a measurement front end for a conversion and writes the result byte into the value RAM at a location derived from the channel's position in the list. The converter, the tachometer counters and the limit comparison all sit outside the block. The only link to them is a request/done handshake that carries one result byte.

The loop runs only while the start control bit is set and the interrupt-clear control bit is clear. When the loop is stopped in the middle of a conversion, the conversion in flight still completes and its result is stored. After that the block parks. Once both bits allow scanning again, the next pass starts over from the temperature channel. Passes repeat at a fixed period, given in clock cycles by a parameter. After the last channel of each pass, a one-cycle strobe tells downstream limit logic that a fresh set of results is ready.

Top module: `chan_scan_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `conv_req`, `ram_we` and `pass_done` are low.
- R2: Scanning is allowed only when `start_en` is 1 and `int_clear` is 0. When scanning is not allowed and no conversion is outstanding, `conv_req` stays low. When the block is idle and scanning becomes allowed, `conv_req` goes high one clock later with `conv_chan` = 0.
- R3: Within a pass, `conv_chan` takes the values 0 to 8 in order: 0 temperature, 1 Vccp2, 2 +12V, 3 +5V, 4 +3.3V, 5 Vccp1, 6 +2.5V, 7 fan 1, 8 fan 2. The index advances only when a result is accepted, and it holds steady while a request is outstanding.
- R4: Each accepted result (`conv_req` and `conv_done` both high at a clock edge) produces exactly one cycle of `ram_we` in the next cycle. In that cycle `ram_addr` = BASE_ADDR + channel index and `ram_wdata` = the accepted `conv_data`.
- R5: `conv_req` stays high until `conv_done` is seen. A `conv_done` pulse while `conv_req` is low is ignored and causes no RAM write.
- R6: `pass_done` is high for exactly one cycle, in the same cycle as the RAM write for channel 8.
- R7: While scanning stays allowed, each pass begins PERIOD_CYC cycles after the previous one began. If a pass takes longer than that, the next one begins one cycle after its `pass_done`.
- R8: If scanning is disallowed while a request is outstanding, the request stays high until `conv_done` and the result is written. After that `conv_req` goes low, and the next pass begins at channel 0.
- R9: If scanning is disallowed while the block waits between passes, the block goes idle. When scanning is allowed again, a pass starts one cycle later at channel 0 without waiting for the period to end.
- R10: `shutdown` is high exactly when `start_en` is 0 and no conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_en | input | 1 | Start control bit; 0 stops the loop and leads to shutdown |
| int_clear | input | 1 | Interrupt-clear control bit; 1 halts scanning |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | SLOT_W (4) | Channel index of the current request |
| conv_done | input | 1 | Front end result valid |
| conv_data | input | DATA_W (8) | Front end result byte |
| ram_we | output | 1 | Value RAM write enable, one cycle per result |
| ram_addr | output | ADDR_W (7) | Value RAM write address |
| ram_wdata | output | DATA_W (8) | Value RAM write data |
| pass_done | output | 1 | One-cycle strobe when the fan 2 result is written |
| shutdown | output | 1 | Monitor stopped by the start bit and quiescent |

## Verification
A wrong channel index or a slot counter that skips would show at `ram_addr` on the very next write, which is one cycle after the accepted result. A lost or stuck state shows in the same way: `conv_req` would either fail to rise in the cycle after gating opens, or stay high with no front-end activity. A period timer that is off by even one cycle moves the next channel-0 request, so the start-to-start spacing shows the error by the second pass. A wrong drain rule on gate removal shows as a missing write of the in-flight channel, or as a restart at a non-zero index.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_CONV = 2'd1,
    SC_HOLD = 2'd2
  } scan_state_e;

  // temperature, five voltages plus +2.5V, two fans
  localparam int unsigned SCAN_SLOTS = 9;

  // value RAM location of a slot
  function automatic logic [15:0] place_addr(input logic [15:0] base,
                                             input logic [7:0]  slot);
    return base + {8'd0, slot};
  endfunction

  // period elapsed once the age has reached period-1
  function automatic logic period_due(input logic [31:0] age,
                                      input logic [31:0] period);
    return ({1'b0, age} + 33'd1) >= {1'b0, period};
  endfunction

endpackage

// File: rtl/scan_slot_ctr.sv
module scan_slot_ctr #(
  parameter int unsigned NUM_SLOTS = 9,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic              last
);

  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NUM_SLOTS - 1);

  assign last = (slot == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (clr) begin
      slot <= '0;
    end else if (adv && !last) begin
      slot <= slot + 1'b1;
    end
  end

endmodule

// File: rtl/scan_age_timer.sv
module scan_age_timer
  import chan_scan_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 20000000,
  localparam int unsigned AGE_W = $clog2(PERIOD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic due
);

  logic [AGE_W-1:0] age;

  assign due = period_due(32'(age), 32'(PERIOD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (clr) begin
      age <= '0;
    end else if (tick && !due) begin
      age <= age + 1'b1;
    end
  end

endmodule

// File: rtl/scan_result_reg.sv
module scan_result_reg
  import chan_scan_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOT_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last_in,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              pass_done
);

  logic [15:0] addr_full;

  assign addr_full = place_addr(16'(BASE_ADDR), 8'(slot_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we        <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      pass_done <= 1'b0;
    end else begin
      we        <= take;
      pass_done <= take && last_in;
      if (take) begin
        addr  <= ADDR_W'(addr_full);
        wdata <= data_in;
      end
    end
  end

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 20000000,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h20,
  localparam int unsigned NUM_SLOTS = SCAN_SLOTS,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic              int_clear,
  output logic              conv_req,
  output logic [SLOT_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              pass_done,
  output logic              shutdown
);

  scan_state_e state, state_nx;

  // named internal events
  logic run_ok;
  logic accept;
  logic pass_begin;
  logic go_idle;
  logic slot_last;
  logic period_ok;
  logic slot_adv;

  assign run_ok = start_en && !int_clear;
  assign accept = (state == SC_CONV) && conv_done;

  always_comb begin
    state_nx   = state;
    pass_begin = 1'b0;
    go_idle    = 1'b0;
    unique case (state)
      SC_IDLE: begin
        if (run_ok) begin
          state_nx   = SC_CONV;
          pass_begin = 1'b1;
        end
      end
      SC_CONV: begin
        if (accept) begin
          if (!run_ok) begin
            state_nx = SC_IDLE;
            go_idle  = 1'b1;
          end else if (slot_last) begin
            state_nx = SC_HOLD;
          end
        end
      end
      SC_HOLD: begin
        if (!run_ok) begin
          state_nx = SC_IDLE;
          go_idle  = 1'b1;
        end else if (period_ok) begin
          state_nx   = SC_CONV;
          pass_begin = 1'b1;
        end
      end
      default: begin
        state_nx = SC_IDLE;
        go_idle  = 1'b1;
      end
    endcase
  end

  assign slot_adv = accept && run_ok && !slot_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SC_IDLE;
    end else begin
      state <= state_nx;
    end
  end

  scan_slot_ctr #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pass_begin || go_idle),
    .adv  (slot_adv),
    .slot (conv_chan),
    .last (slot_last)
  );

  scan_age_timer #(
    .PERIOD_CYC(PERIOD_CYC)
  ) u_age (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pass_begin),
    .tick (state != SC_IDLE),
    .due  (period_ok)
  );

  scan_result_reg #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SLOT_W   (SLOT_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .last_in  (slot_last),
    .slot_in  (conv_chan),
    .data_in  (conv_data),
    .we       (ram_we),
    .addr     (ram_addr),
    .wdata    (ram_wdata),
    .pass_done(pass_done)
  );

  assign conv_req = (state == SC_CONV);
  assign shutdown = !start_en && (state != SC_CONV);

endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned NUM_SLOTS = 9,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_ok,
  input logic              conv_req,
  input logic [SLOT_W-1:0] conv_chan,
  input logic              conv_done,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              pass_done,
  input logic              shutdown
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_SLOTS - 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!conv_req && !ram_we && !pass_done); // R1
    end
  end

  AST_GATED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && !conv_req) |=> !conv_req); // R2

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_chan < SLOT_W'(NUM_SLOTS))); // R3

  AST_CHAN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> $stable(conv_chan)); // R3

  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> (ram_we && ram_addr == BASE_ADDR + ADDR_W'($past(conv_chan)))); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> conv_req); // R5

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_req && conv_done) |=> !ram_we); // R5

  AST_PASS_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (ram_we && ram_addr == LAST_ADDR)); // R6

  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !conv_req); // R10

endmodule

bind chan_scan_seq chan_scan_seq_chk #(
  .ADDR_W   (ADDR_W),
  .SLOT_W   (SLOT_W),
  .NUM_SLOTS(NUM_SLOTS),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_ok   (run_ok),
  .conv_req (conv_req),
  .conv_chan(conv_chan),
  .conv_done(conv_done),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .pass_done(pass_done),
  .shutdown (shutdown)
);

// File: tb/sim_chan_scan_seq.sv
module sim_chan_scan_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int P    = 60;
  localparam int BASE = 'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_en = 1'b0;
  logic       int_clear = 1'b0;
  logic       conv_done = 1'b0;
  logic [7:0] conv_data = 8'h00;
  logic       conv_req;
  logic [3:0] conv_chan;
  logic       ram_we;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       pass_done;
  logic       shutdown;

  always #2.5 clk = ~clk;

  chan_scan_seq #(
    .PERIOD_CYC(P),
    .ADDR_W    (7),
    .DATA_W    (8),
    .BASE_ADDR (7'(BASE))
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_en(start_en), .int_clear(int_clear),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .pass_done(pass_done), .shutdown(shutdown)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // reference model: busy flag, waiting flag, slot number, pass age
  bit m_busy, m_wait;
  int m_slot, m_age;
  bit e_we, e_pd;
  int e_addr, e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wait = 0; m_slot = 0; m_age = 0;
      e_we = 0; e_pd = 0; e_addr = 0; e_data = 0;
    end else begin
      bit go;
      go = start_en && !int_clear;
      e_we = 0; e_pd = 0;
      if (m_busy) begin
        m_age++;
        if (conv_done) begin
          e_we = 1; e_addr = BASE + m_slot; e_data = conv_data;
          e_pd = (m_slot == 8);
          if (!go) begin m_busy = 0; m_slot = 0; end
          else if (m_slot == 8) begin m_busy = 0; m_wait = 1; end
          else m_slot++;
        end
      end else if (m_wait) begin
        if (!go) begin m_wait = 0; m_slot = 0; end
        else if (m_age + 1 >= P) begin m_wait = 0; m_busy = 1; m_slot = 0; m_age = 0; end
        else m_age++;
      end else if (go) begin
        m_busy = 1; m_slot = 0; m_age = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // front end emulation
  bit fe_auto = 0;
  int fe_lat = 2;
  int fe_wait = 0;
  logic [7:0] seed = 8'h3c;

  // pass-start bookkeeping
  int cyc = 0;
  int n_starts = 0, last_start = 0, prev_start = 0, last_pd = 0;
  bit prev_first = 0;

  task automatic compare();
    chk(conv_req == m_busy, "R2 conv_req", conv_req, m_busy);
    if (m_busy) chk(conv_chan == 4'(m_slot), "R3 conv_chan", conv_chan, m_slot);
    chk(ram_we == e_we, "R4 ram_we", ram_we, e_we);
    if (e_we) begin
      chk(ram_addr == 7'(e_addr), "R4 ram_addr", ram_addr, e_addr);
      chk(ram_wdata == 8'(e_data), "R4 ram_wdata", ram_wdata, e_data);
    end
    chk(pass_done == e_pd, "R6 pass_done", pass_done, e_pd);
    chk(shutdown == (!start_en && !m_busy), "R10 shutdown", shutdown, !start_en && !m_busy);
  endtask

  task automatic drive_fe();
    if (!fe_auto) return;
    if (conv_done) begin
      conv_done = 0; fe_wait = 0;
    end else if (conv_req) begin
      if (fe_wait >= fe_lat) begin
        conv_done = 1;
        seed = seed * 8'd5 + 8'd3;
        conv_data = seed;
      end else fe_wait++;
    end else fe_wait = 0;
  endtask

  task automatic step();
    bit first;
    @(posedge clk);
    #1;
    cyc++;
    compare();
    first = conv_req && conv_chan == 0;
    if (first && !prev_first) begin
      prev_start = last_start; last_start = cyc; n_starts++;
    end
    prev_first = first;
    if (pass_done) last_pd = cyc;
    drive_fe();
  endtask

  task automatic wait_starts(input int n);
    int target;
    target = n_starts + n;
    for (int i = 0; i < 2000 && n_starts < target; i++) step();
    chk(n_starts >= target, "R7 pass start seen", n_starts, target);
  endtask

  task automatic wait_chan(input int ch);
    bit seen;
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      step();
      seen = conv_req && conv_chan == 4'(ch);
    end
    chk(seen, "R3 channel reached", ch, ch);
  endtask

  task automatic wait_pd();
    bit seen;
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      step();
      seen = pass_done;
    end
    chk(seen, "R6 pass_done seen", 0, 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!conv_req && !ram_we && !pass_done, "R1 reset outputs", conv_req, 0);
    chk(shutdown == 1, "R10 shutdown in reset", shutdown, 1);
    rst_n = 1;
    step();
    chk(!conv_req && !ram_we && !pass_done, "R1 after reset", conv_req, 0);
    step();
    chk(!conv_req, "R2 idle without start", conv_req, 0);

    // R2/R3/R4: start scanning, short latency
    fe_auto = 1; fe_lat = 2;
    start_en = 1;
    step();
    chk(conv_req && conv_chan == 0, "R2 start next cycle", conv_chan, 0);
    wait_starts(2);
    chk(last_start - prev_start == P, "R7 period spacing", last_start - prev_start, P);
    wait_starts(1);
    chk(last_start - prev_start == P, "R7 period spacing again", last_start - prev_start, P);

    // R7 overrun: long latency pass exceeds the period
    fe_lat = 8;
    wait_starts(1);
    wait_pd();
    wait_starts(1);
    chk(last_start - last_pd == 1, "R7 overrun restart", last_start - last_pd, 1);

    // R5: stray done while waiting between passes
    fe_lat = 1;
    wait_pd();
    fe_auto = 0; conv_done = 0;
    step();
    conv_done = 1; conv_data = 8'hEE;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!ram_we, "R5 stray done ignored", ram_we, 0);
    end
    conv_done = 0; fe_auto = 1;

    // R8: int_clear raised mid conversion
    fe_lat = 6;
    wait_chan(3);
    step();
    int_clear = 1;
    begin
      bit wr;
      wr = 0;
      for (int i = 0; i < 40 && !wr; i++) begin
        step();
        wr = ram_we;
      end
      chk(wr && ram_addr == 7'(BASE + 3), "R8 in-flight result written", ram_addr, BASE + 3);
    end
    chk(!conv_req, "R8 request dropped", conv_req, 0);
    for (int i = 0; i < 8; i++) step();
    chk(!conv_req, "R2 gated stays idle", conv_req, 0);
    int_clear = 0;
    step();
    chk(conv_req && conv_chan == 0, "R8 restart at channel 0", conv_chan, 0);

    // R9/R10: start cleared during the wait between passes
    fe_lat = 1;
    wait_pd();
    step();
    start_en = 0;
    step();
    chk(shutdown && !conv_req, "R10 shutdown in wait", shutdown, 1);
    for (int i = 0; i < 5; i++) step();
    start_en = 1;
    step();
    chk(conv_req && conv_chan == 0, "R9 immediate restart", conv_chan, 0);

    // R10: start cleared while a request is outstanding
    fe_lat = 5;
    wait_chan(2);
    start_en = 0;
    step();
    chk(!shutdown && conv_req, "R10 no shutdown while busy", shutdown, 0);
    begin
      bit wr;
      wr = 0;
      for (int i = 0; i < 40 && !wr; i++) begin
        step();
        wr = ram_we;
      end
      chk(wr && ram_addr == 7'(BASE + 2), "R8 drain on stop", ram_addr, BASE + 2);
    end
    chk(shutdown, "R10 shutdown after drain", shutdown, 1);
    for (int i = 0; i < 5; i++) step();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule